// File: doc/BRIEF.md
# Serial Test Pattern Bit-Error Monitor

This block checks a serial bit stream, one bit per qualified clock cycle, against a known test pattern. The expected sequence can be constant zeros, constant ones, a programmable 16-bit word, or one of two maximal-length pseudorandom sequences. Every bit that differs from the expected value adds one to a 16-bit error counter. That counter either stops at its ceiling or wraps, depending on a mode bit. A sticky error flag records that at least one error has been seen. The flag drives an interrupt output through a mask bit.

For the pseudorandom sequences the monitor does not need a shared seed. It loads its reference shift register straight from the received bits. It declares itself aligned after 32 consecutive bits agree with the sequence recurrence, and only then does it count errors. An invert bit complements the expected stream so an inverted line can be checked. A small register port configures the block and reads it back. The sticky flag is cleared either by reading it or by writing a one to it, as set by a mode bit. Selecting the bits of interest from a framed stream is left to the logic that drives the bit-valid strobe.

Top module: `tpm_monitor`

## Requirements
- R1: After reset the error count reads 0, the status register reads 0 in bit 0, the irq output is 0, the configuration register (address 0) reads 0, and the mask register (address 4) reads 1.
- R2: The error count (address 2) increases by exactly one for each cycle where bit_vld is 1 and bit_in differs from the expected bit. Cycles with bit_vld at 0 leave the count unchanged whatever bit_in is.
- R3: With configuration bit 4 at 0 (saturate), an error while the count is 0xFFFF leaves it at 0xFFFF.
- R4: With configuration bit 4 at 1 (wrap), an error while the count is 0xFFFF takes it to 0x0000.
- R5: Pattern code 2 in configuration bits 2:0 compares against the word in address 1, starting with bit 15 and moving down to bit 0, then repeating. Writing the configuration register restarts at bit 15.
- R6: Configuration bit 3 complements the expected stream. Pattern code 0 (all zeros) with bit 3 set expects ones.
- R7: Pattern codes 3 (x^9+x^5+1: each bit is the XOR of the bits 9 and 5 positions earlier) and 4 (x^15+x^14+1) hunt after a configuration write. While hunting, status bit 1 reads 0 and no error is counted. After 32 consecutive received bits follow the recurrence, status bit 1 reads 1 and mismatches are counted. Codes 0, 1 and 2 are aligned at once.
- R8: Status bit 0 (address 3) is set by any counted error and stays set. irq is 1 exactly when status bit 0 is 1 and the mask bit (address 4 bit 0) is 0.
- R9: With configuration bit 5 at 1, a read of address 3 returns the current status and clears bit 0 at the end of that cycle.
- R10: With configuration bit 5 at 0, writing address 3 with bit 0 set clears status bit 0. Writing it with bit 0 clear has no effect.
- R11: A counted error in the same cycle as a status clear leaves status bit 0 set.
- R12: Any write to address 2 sets the error count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received serial data bit |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for clear-on-read) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, valid in the same cycle |
| irq | output | 1 | Unmasked error interrupt |

## Verification
Read data is combinational from reg_addr. A bit presented before a clock edge therefore changes the count and status at that edge, and a read in the very next cycle shows the change. The bench drives every input on the falling edge and samples reg_rdata one time unit later. It never looks at the edge where a value is being written. Alignment in the pseudorandom modes is checked by bit count rather than by cycle. The bench reads status bit 1 after 20 bits, which is too few to be aligned. It reads it again after 60 bits, which is enough even when one corrupted bit is in the hunt window. A clear-on-read is checked by two reads in a row: the first returns 1 and the second returns 0.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    localparam int DATA_W   = 16;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 3;
    localparam int SYNC_LEN = 32;
    localparam int LFSR_W   = 15;

    localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
    localparam logic [ADDR_W-1:0] A_USER   = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd4;

    localparam logic [2:0] PAT_ZEROS  = 3'd0;
    localparam logic [2:0] PAT_ONES   = 3'd1;
    localparam logic [2:0] PAT_USER   = 3'd2;
    localparam logic [2:0] PAT_PRBS9  = 3'd3;
    localparam logic [2:0] PAT_PRBS15 = 3'd4;

    typedef struct packed {
        logic       clr_on_rd;
        logic       wrap;
        logic       inv;
        logic [2:0] pat;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic {ST_HUNT, ST_LOCK} sync_e;

    function automatic logic is_prbs(input logic [2:0] pat);
        return (pat == PAT_PRBS9) || (pat == PAT_PRBS15);
    endfunction

    // Next bit from recurrence; s[0] is the most recent bit.
    function automatic logic prbs_next(input logic [2:0] pat,
                                       input logic [LFSR_W-1:0] s);
        if (pat == PAT_PRBS9)
            return s[8] ^ s[4];
        return s[14] ^ s[13];
    endfunction

endpackage

// File: rtl/tpm_ref_gen.sv
module tpm_ref_gen
    import tpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  cfg_t              cfg,
    input  logic [DATA_W-1:0] user_word,
    output logic              err_event,
    output logic              locked
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int MC_W  = $clog2(SYNC_LEN + 1);

    logic [LFSR_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic [MC_W-1:0]   match_cnt;
    sync_e             st;

    logic data_n;
    logic pred;
    logic expect_bit;
    logic prbs_mode;

    assign data_n    = bit_in ^ cfg.inv;
    assign prbs_mode = is_prbs(cfg.pat);
    assign pred      = prbs_next(cfg.pat, shreg);

    always_comb begin
        case (cfg.pat)
            PAT_ONES:   expect_bit = 1'b1;
            PAT_USER:   expect_bit = user_word[idx];
            PAT_PRBS9,
            PAT_PRBS15: expect_bit = pred;
            default:    expect_bit = 1'b0;
        endcase
    end

    assign locked    = !prbs_mode || (st == ST_LOCK);
    assign err_event = bit_vld && locked && (data_n != expect_bit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            shreg     <= '0;
            idx       <= IDX_W'(DATA_W - 1);
            match_cnt <= '0;
            st        <= ST_HUNT;
        end else if (bit_vld) begin
            idx <= idx - 1'b1;
            if (prbs_mode) begin
                if (st == ST_LOCK) begin
                    shreg <= {shreg[LFSR_W-2:0], pred};
                end else begin
                    shreg <= {shreg[LFSR_W-2:0], data_n};
                    if (pred == data_n) begin
                        if (match_cnt == MC_W'(SYNC_LEN - 1))
                            st <= ST_LOCK;
                        match_cnt <= match_cnt + 1'b1;
                    end else begin
                        match_cnt <= '0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tpm_err_counter.sv
module tpm_err_counter
    import tpm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wrap,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic at_top;
    assign at_top = (cnt == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && !(at_top && !wrap))
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/tpm_regs.sv
module tpm_regs
    import tpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              err_event,
    input  logic              locked,
    input  logic [CNT_W-1:0]  cnt,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] user_word,
    output logic              mask_bit,
    output logic              sticky,
    output logic              clr_req,
    output logic              cnt_wclr,
    output logic              restart,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);
    logic wr_cfg, wr_user, wr_mask, wr_stat, rd_stat;

    assign wr_cfg  = wr && (addr == A_CFG);
    assign wr_user = wr && (addr == A_USER);
    assign wr_mask = wr && (addr == A_MASK);
    assign wr_stat = wr && (addr == A_STATUS);
    assign rd_stat = rd && (addr == A_STATUS);

    assign cnt_wclr = wr && (addr == A_COUNT);
    assign restart  = wr_cfg;
    assign clr_req  = cfg.clr_on_rd ? rd_stat : (wr_stat && wdata[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            user_word <= '0;
            mask_bit  <= 1'b1;
            sticky    <= 1'b0;
        end else begin
            if (wr_cfg)  cfg       <= cfg_t'(wdata[CFG_W-1:0]);
            if (wr_user) user_word <= wdata;
            if (wr_mask) mask_bit  <= wdata[0];
            // a new error wins over a clear in the same cycle
            sticky <= err_event || (sticky && !clr_req);
        end
    end

    assign irq = sticky && !mask_bit;

    always_comb begin
        case (addr)
            A_CFG:    rdata = DATA_W'(cfg);
            A_USER:   rdata = user_word;
            A_COUNT:  rdata = DATA_W'(cnt);
            A_STATUS: rdata = DATA_W'({locked, sticky});
            A_MASK:   rdata = DATA_W'(mask_bit);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tpm_monitor.sv
module tpm_monitor
    import tpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    cfg_t              cfg;
    logic [DATA_W-1:0] user_word;
    logic              mask_bit;
    logic              sticky;
    logic              clr_req;
    logic              cnt_wclr;
    logic              restart;
    logic              err_event;
    logic              locked;
    logic              wrap;
    logic [CNT_W-1:0]  err_cnt;

    assign wrap = cfg.wrap;

    tpm_ref_gen u_ref (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .cfg       (cfg),
        .user_word (user_word),
        .err_event (err_event),
        .locked    (locked)
    );

    tpm_err_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_wclr),
        .wrap (wrap),
        .inc  (err_event),
        .cnt  (err_cnt)
    );

    tpm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .err_event (err_event),
        .locked    (locked),
        .cnt       (err_cnt),
        .cfg       (cfg),
        .user_word (user_word),
        .mask_bit  (mask_bit),
        .sticky    (sticky),
        .clr_req   (clr_req),
        .cnt_wclr  (cnt_wclr),
        .restart   (restart),
        .irq       (irq),
        .rdata     (reg_rdata)
    );

endmodule

// File: rtl/tpm_monitor_chk.sv
module tpm_monitor_chk
    import tpm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_vld,
    input logic             err_event,
    input logic             locked,
    input logic             cnt_wclr,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic             sticky,
    input logic             clr_req,
    input logic             mask_bit,
    input logic             irq
);
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld && !cnt_wclr) |=> $stable(cnt));

    assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt == {CNT_W{1'b1}} && !wrap && !cnt_wclr) |=> (cnt == {CNT_W{1'b1}}));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt == {CNT_W{1'b1}} && wrap && err_event && !cnt_wclr) |=> (cnt == '0));

    assert_hunt_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (!locked && !cnt_wclr) |=> $stable(cnt));

    assert_err_sets_R8: assert property (@(posedge clk) disable iff (rst)
        err_event |=> sticky);

    assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        mask_bit |-> !irq);

    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (sticky && clr_req && !err_event) |=> !sticky);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_req && err_event) |=> sticky);

endmodule

bind tpm_monitor tpm_monitor_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .err_event (err_event),
    .locked    (locked),
    .cnt_wclr  (cnt_wclr),
    .wrap      (wrap),
    .cnt       (err_cnt),
    .sticky    (sticky),
    .clr_req   (clr_req),
    .mask_bit  (mask_bit),
    .irq       (irq)
);

// File: tb/tpm_monitor_bench.sv
module tpm_monitor_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] rd_val;
    logic [14:0] gen;

    always #4 clk = ~clk;

    tpm_monitor u_tpm_monitor (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    // Every input is set on a falling edge and holds for exactly one rising edge.
    task automatic drive(input logic w, input logic r, input logic [2:0] a,
                         input logic [15:0] d, input logic v, input logic b);
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        bit_vld = v; bit_in = b;
        #1 rd_val = reg_rdata;
    endtask

    task automatic idle();                       drive(0, 0, 3'd0, 16'h0, 0, 0); endtask
    task automatic wr(input logic [2:0] a, input logic [15:0] d); drive(1, 0, a, d, 0, 0); endtask
    task automatic rd(input logic [2:0] a);      drive(0, 1, a, 16'h0, 0, 0); endtask
    task automatic send(input logic b);          drive(0, 0, 3'd0, 16'h0, 1, b); endtask

    function automatic logic gen_step9();
        logic nb;
        nb  = gen[8] ^ gen[4];
        gen = {gen[13:0], nb};
        return nb;
    endfunction

    function automatic logic gen_step15();
        logic nb;
        nb  = gen[14] ^ gen[13];
        gen = {gen[13:0], nb};
        return nb;
    endfunction

    task automatic t_reset();
        rd(3'd2); check("R1 count", rd_val, 16'h0000);
        rd(3'd3); check("R1 status bit0", {15'b0, rd_val[0]}, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);
        rd(3'd0); check("R1 cfg", rd_val, 16'h0000);
        rd(3'd4); check("R1 mask", rd_val, 16'h0001);
    endtask

    task automatic t_count();
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0000);
        send(1); send(0); send(1); send(1); send(0);
        idle();
        rd(3'd2); check("R2 three mismatches", rd_val, 16'd3);
        for (int i = 0; i < 5; i++) drive(0, 0, 3'd0, 16'h0, 0, 1);
        rd(3'd2); check("R2 invalid bits ignored", rd_val, 16'd3);
        wr(3'd2, 16'h1234);
        rd(3'd2); check("R12 write clears count", rd_val, 16'd0);
    endtask

    task automatic t_status();
        check("R8 masked irq", {15'b0, irq}, 16'h0000);
        wr(3'd4, 16'h0000); idle();
        check("R8 unmasked irq", {15'b0, irq}, 16'h0001);
        wr(3'd3, 16'h0000);
        rd(3'd3); check("R10 write zero no effect", {15'b0, rd_val[0]}, 16'h0001);
        wr(3'd3, 16'h0001);
        rd(3'd3); check("R10 write one clears", {15'b0, rd_val[0]}, 16'h0000);
        check("R8 irq follows status", {15'b0, irq}, 16'h0000);
        drive(1, 0, 3'd3, 16'h0001, 1, 1);
        rd(3'd3); check("R11 set beats write clear", {15'b0, rd_val[0]}, 16'h0001);
        wr(3'd0, 16'h0020);
        rd(3'd3); check("R9 read returns set", {15'b0, rd_val[0]}, 16'h0001);
        rd(3'd3); check("R9 read cleared", {15'b0, rd_val[0]}, 16'h0000);
        drive(0, 1, 3'd3, 16'h0, 1, 1);
        rd(3'd3); check("R11 set beats read clear", {15'b0, rd_val[0]}, 16'h0001);
        wr(3'd4, 16'h0001);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_user();
        logic [15:0] w;
        int mism;
        w = 16'hA5C3;
        mism = 0;
        wr(3'd1, w);
        wr(3'd0, 16'h0002);
        wr(3'd2, 16'h0000);
        for (int k = 15; k >= 0; k--) send(w[k]);
        idle();
        rd(3'd2); check("R5 msb-first match", rd_val, 16'd0);
        for (int k = 0; k < 16; k++) begin
            send(w[k]);
            if (w[k] != w[15-k]) mism++;
        end
        idle();
        rd(3'd2); check("R5 reversed order mismatches", rd_val, 16'(mism));
    endtask

    task automatic t_invert();
        wr(3'd0, 16'h0008);
        wr(3'd2, 16'h0000);
        for (int i = 0; i < 8; i++) send(1);
        idle();
        rd(3'd2); check("R6 inverted zeros accept ones", rd_val, 16'd0);
        send(0); send(0); idle();
        rd(3'd2); check("R6 inverted zeros flag zeros", rd_val, 16'd2);
    endtask

    task automatic t_prbs();
        logic nb;
        wr(3'd0, 16'h0003);
        wr(3'd2, 16'h0000);
        gen = 15'h01FF;
        for (int i = 0; i < 20; i++) begin
            nb = gen_step9();
            send((i == 5) ? ~nb : nb);
        end
        idle();
        rd(3'd3); check("R7 not aligned after 20 bits", {15'b0, rd_val[1]}, 16'h0000);
        rd(3'd2); check("R7 no count while hunting", rd_val, 16'd0);
        for (int i = 0; i < 40; i++) send(gen_step9());
        idle();
        rd(3'd3); check("R7 aligned prbs9", {15'b0, rd_val[1]}, 16'h0001);
        rd(3'd2); check("R7 clean prbs9", rd_val, 16'd0);
        send(~gen_step9());
        send(gen_step9());
        idle();
        rd(3'd2); check("R7 prbs9 single error", rd_val, 16'd1);

        wr(3'd0, 16'h000C);
        wr(3'd2, 16'h0000);
        gen = 15'h2B6D;
        for (int i = 0; i < 60; i++) send(~gen_step15());
        idle();
        rd(3'd3); check("R7 aligned inverted prbs15", {15'b0, rd_val[1]}, 16'h0001);
        rd(3'd2); check("R6 clean inverted prbs15", rd_val, 16'd0);
        send(gen_step15());
        idle();
        rd(3'd2); check("R6 inverted prbs15 error", rd_val, 16'd1);
    endtask

    task automatic t_satroll();
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'h0000);
        for (int i = 0; i < 65535; i++) send(0);
        idle();
        rd(3'd2); check("R3 reaches top", rd_val, 16'hFFFF);
        send(0); send(0); send(0); idle();
        rd(3'd2); check("R3 saturates", rd_val, 16'hFFFF);
        wr(3'd0, 16'h0011);
        send(0); idle();
        rd(3'd2); check("R4 wraps to zero", rd_val, 16'h0000);
        send(0); idle();
        rd(3'd2); check("R4 counts after wrap", rd_val, 16'h0001);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_status();
        t_user();
        t_invert();
        t_prbs();
        t_satroll();
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule